// File: doc/BRIEF.md
# Pin change interrupt detector

This block watches nine input pins split into two groups and raises one flag per group whenever an enabled pin of that group changes level. The wide group holds pins 0 to 7 and the narrow group holds pin 8 alone. Each group has its own per-pin mask. The block also has a two-bit enable that gates each flag onto an interrupt request output. The block looks only at the pin level, so an output driver that wraps its own level back into `pin_i` can trigger the interrupt from software.

Each pin first passes through a latch that is open while the clock is low. A rising-edge flop then synchronizes the latched value. A toggle is any difference between the synchronized value and the value one cycle earlier. In each group the masked toggles are OR-ed into a registered one-cycle set pulse. The group flag sets on the edge after that pulse. Software clears a flag by writing a one to its bit. A small write port reaches the masks, the enables and the flag-clear register.

Top module: `pin_change_irq`

## Requirements
- R1: A level change on any of pins 0 to 7 whose mask bit is set makes `flag_o[0]` go high. Several such changes in the same cycle give one set flag.
- R2: Pin 8 affects only `flag_o[1]`, and pins 0 to 7 never affect `flag_o[1]`.
- R3: A pin whose mask bit is 0 does not change either flag.
- R4: A rising change and a falling change both set the flag.
- R5: A new level applied while the clock is low before rising edge k shows on the flag after edge k+2. The flag is still low after edge k+1.
- R6: Writing address 3 with data bit g set to 1 clears `flag_o[g]`. Writing 0 to bit g leaves the flag unchanged. A flag that is not cleared and not set holds its value.
- R7: If a set pulse and a clear of the same group reach the same clock edge, the flag ends up set.
- R8: `irq_o[g]` is high exactly when `flag_o[g]` and enable bit g are both high.
- R9: After reset, masks, enables and flags are zero. Pins that sit at nonzero levels through reset release cause no flag.
- R10: The write port decodes addresses as follows. Address 0 writes the group 0 mask from data bits 7:0, with bit n for pin n. Address 1 writes the group 1 mask from data bit 0. Address 2 writes the enables from data bits 1:0, with bit g for group g. Address 3 is the write-one-to-clear flag register, with bit g for group g.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. It also controls the pin latches, which are open while it is low |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 9 | Raw pin levels. Bits 7:0 form group 0 and bit 8 forms group 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| flag_o | output | 2 | Per-group change flags |
| irq_o | output | 2 | Per-group interrupt requests |

## Verification
The hardest case is a collision between a set pulse and a clear on the same edge. The set pulse is internal, so it can only be reached by timing a pin toggle against a register write. The stimulus toggles an enabled pin two cycles before it issues the clear write, which makes the registered set pulse land on the same edge as the clear. The flag must then stay high. The latency claim gets its own checks: the flag must still read low one edge before it is due.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    localparam int NUM_GROUPS = 2;

    typedef enum logic [1:0] {
        REG_MASK_LO = 2'd0,
        REG_MASK_HI = 2'd1,
        REG_ENABLE  = 2'd2,
        REG_CLEAR   = 2'd3
    } pcd_reg_e;
endpackage

// File: rtl/pcd_pin_stage.sv
module pcd_pin_stage #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] toggle_o
);
    logic [N-1:0] lat;

    // Per-pin latch, open during the low clock phase
    for (genvar p = 0; p < N; p++) begin : g_lat
        always_latch begin
            if (!clk) lat[p] <= pin_i[p];
        end
    end

    typedef struct packed {
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d.sync = lat;
        // In reset the history follows the pin so release sees no change
        s_d.prev = rst_n ? s_q.sync : lat;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign toggle_o = s_q.sync ^ s_q.prev;
endmodule

// File: rtl/pcd_group.sv
module pcd_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] toggle_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_data_i,
    input  logic         clr_i,
    input  logic         en_i,
    output logic         set_o,
    output logic [W-1:0] mask_o,
    output logic         flag_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         set;
        logic         flag;
    } grp_t;

    grp_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (mask_we_i) g_d.mask = mask_data_i;
        g_d.set  = |(g_q.mask & toggle_i);
        g_d.flag = (g_q.flag & ~clr_i) | g_q.set;
        if (!rst_n) g_d = '0;
    end

    always_ff @(posedge clk) begin
        g_q <= g_d;
    end

    assign set_o  = g_q.set;
    assign mask_o = g_q.mask;
    assign flag_o = g_q.flag;
    assign irq_o  = g_q.flag & en_i;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
    parameter int G0_PINS = 8,
    parameter int G1_PINS = 1,
    parameter int DATA_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [G0_PINS+G1_PINS-1:0] pin_i,
    input  logic                       wr_en_i,
    input  logic [1:0]                 wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic [1:0]                 flag_o,
    output logic [1:0]                 irq_o
);
    import pcd_pkg::*;

    localparam int NPINS = G0_PINS + G1_PINS;

    logic [NPINS-1:0]      toggle;
    logic [NUM_GROUPS-1:0] group_set;
    logic [NUM_GROUPS-1:0] mask_none;

    typedef struct packed {
        logic [NUM_GROUPS-1:0] en;
    } top_t;

    top_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (wr_en_i && wr_addr_i == REG_ENABLE) t_d.en = wr_data_i[NUM_GROUPS-1:0];
        if (!rst_n) t_d = '0;
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    pcd_pin_stage #(.N(NPINS)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .toggle_o (toggle)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int W  = (g == 0) ? G0_PINS : G1_PINS;
        localparam int LO = (g == 0) ? 0 : G0_PINS;
        localparam pcd_reg_e MADDR = (g == 0) ? REG_MASK_LO : REG_MASK_HI;

        logic [W-1:0] mask;

        pcd_group #(.W(W)) u_grp (
            .clk         (clk),
            .rst_n       (rst_n),
            .toggle_i    (toggle[LO +: W]),
            .mask_we_i   (wr_en_i && wr_addr_i == MADDR),
            .mask_data_i (wr_data_i[W-1:0]),
            .clr_i       (wr_en_i && wr_addr_i == REG_CLEAR && wr_data_i[g]),
            .en_i        (t_q.en[g]),
            .set_o       (group_set[g]),
            .mask_o      (mask),
            .flag_o      (flag_o[g]),
            .irq_o       (irq_o[g])
        );

        assign mask_none[g] = ~|mask;
    end
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int NPINS = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [7:0]       wr_data_i,
    input logic [NPINS-1:0] toggle,
    input logic [1:0]       group_set,
    input logic [1:0]       mask_none,
    input logic [1:0]       flag_o,
    input logic [1:0]       irq_o
);
    import pcd_pkg::*;

    logic [1:0] clr;
    logic       en_wr;
    assign clr   = (wr_en_i && wr_addr_i == REG_CLEAR) ? wr_data_i[1:0] : 2'b00;
    assign en_wr = wr_en_i && wr_addr_i == REG_ENABLE;

    assert_quiet_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle == '0) |=> (group_set == 2'b00));

    for (genvar g = 0; g < 2; g++) begin : g_chk
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            group_set[g] |=> flag_o[g]);
        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !group_set[g]) |=> !flag_o[g]);
        assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[g] && !group_set[g]) |=> (flag_o[g] == $past(flag_o[g])));
        assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            mask_none[g] |=> !group_set[g]);
        assert_irq_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_wr && !wr_data_i[g]) |=> !irq_o[g]);
    end
endmodule

bind pin_change_irq pcd_checker #(.NPINS(G0_PINS + G1_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i[7:0]),
    .toggle    (toggle),
    .group_set (group_set),
    .mask_none (mask_none),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] pins = 9'h0A5;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] flag_o, irq_o;

    pin_change_irq u_pin_change_irq (
        .clk(clk), .rst_n(rst_n), .pin_i(pins),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [1:0] f;
        logic [1:0] i;
        string      tag;
    } item_t;

    item_t q[$];
    int cnt = 0, checks = 0, fails = 0;
    logic [1:0] me = 2'b00;
    bit done = 0;

    always @(posedge clk) cnt <= cnt + 1;

    task automatic expect_at(int dly, logic [1:0] f, string tag);
        item_t it;
        it.cyc = cnt + dly; it.f = f; it.i = f & me; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: pops expected items when their cycle comes up
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].cyc <= cnt) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.cyc != cnt || flag_o !== it.f || irq_o !== it.i) begin
                    fails++;
                    $display("FAIL %s: cyc %0d/%0d flag %b exp %b irq %b exp %b",
                             it.tag, cnt, it.cyc, flag_o, it.f, irq_o, it.i);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_at(1, 2'b00, "R9 reset state");
        expect_at(4, 2'b00, "R9 no false toggle");
        step(4);
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h01);
        me = 2'b11;
        expect_at(1, 2'b00, "R10 enable write, no flag");
        wr(2'd2, 8'h03);
        // R1 / R5: rising pin1
        pins[1] = ~pins[1];
        expect_at(2, 2'b00, "R5 not yet");
        expect_at(3, 2'b01, "R1 group0 set");
        step(3);
        expect_at(1, 2'b00, "R6 clear");
        wr(2'd3, 8'h01);
        // R3: masked pin5
        pins[5] = ~pins[5];
        expect_at(3, 2'b00, "R3 masked pin");
        step(4);
        // R2: pin8 rising
        pins[8] = 1'b1;
        expect_at(3, 2'b10, "R2 pin8 group1 only");
        step(3);
        expect_at(1, 2'b00, "R6 clear group1");
        wr(2'd3, 8'h02);
        pins[8] = 1'b0;
        expect_at(3, 2'b10, "R4 falling pin8");
        step(3);
        expect_at(1, 2'b00, "R6 clear group1");
        wr(2'd3, 8'h02);
        // R4: pin0 falling
        pins[0] = 1'b0;
        expect_at(3, 2'b01, "R4 falling pin0");
        step(3);
        expect_at(1, 2'b01, "R6 zero write keeps flag");
        wr(2'd3, 8'h00);
        me = 2'b00;
        expect_at(1, 2'b01, "R8 irq gated off");
        wr(2'd2, 8'h00);
        me = 2'b11;
        expect_at(1, 2'b01, "R8 irq on");
        wr(2'd2, 8'h03);
        // R7: set pulse coincides with clear
        pins[3] = ~pins[3];
        step(2);
        expect_at(1, 2'b01, "R7 set wins");
        wr(2'd3, 8'h01);
        expect_at(1, 2'b01, "R7 flag held");
        step(1);
        expect_at(1, 2'b00, "R6 clear after R7");
        wr(2'd3, 8'h01);
        // R3 on group1
        wr(2'd1, 8'h00);
        pins[8] = 1'b1;
        expect_at(3, 2'b00, "R3 group1 masked");
        step(4);
        // R1: several pins at once, some masked
        pins = pins ^ 9'h0C3;
        expect_at(3, 2'b01, "R1 multi pin");
        step(3);
        expect_at(1, 2'b00, "R6 final clear");
        wr(2'd3, 8'h03);
        step(2);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule